// File: doc/BRIEF.md
# Lockable Comparator Control and Status Register

This block is the digital front end of an analog voltage comparator. It holds one 32-bit control word on a plain register bus. Its fields drive the analog macro: on/off, speed/power setting, minus- and plus-input routing, hysteresis, and the reference scaler and divider bridge. The same word also chooses a polarity and one of two timer gates that can suppress the output for a while.

The raw comparator decision enters asynchronously. It passes through a two-stage synchronizer, then is inverted if polarity is set, then gated by enable and by the chosen timer blanking input. The result is driven out and can also be read back as a read-only status bit. Software may set a sticky lock bit. From then on every bit of the word is frozen, the lock bit included, until reset.

The bus has no back-pressure. A write is always accepted, at the clock edge where `bus_we` is high and the address matches. Read data is combinational and follows `bus_addr` in the same cycle. The control and status pins are level signals with no handshake.

Top module: `cmp_ctl_csr`

## Requirements
- R1: After reset every control field and the lock are 0. Reads return 0, `cmp_out` is 0 and `ana_plus_oh` is 3'b001.
- R2: At address `CSR_ADDR`, an unlocked write stores the writable fields, which read back at the same positions. The positions are: enable bit 0, power mode [3:2], minus select [6:4], plus select [8:7], polarity bit 15, hysteresis [17:16], blanking [20:18], bridge enable bit 22, scaler enable bit 23. All other bits except 30 and 31 read 0. Power mode, hysteresis and enable appear unchanged on their output pins.
- R3: Writing 1 to bit 31 sets the lock. While locked, writes change no bit, including bit 31. Only reset clears the lock.
- R4: Bit 30 is read-only. Writes to it are ignored, and it reads as enable AND (synchronized raw result XOR polarity).
- R5: A change on `comp_raw` reaches `cmp_out` and bit 30 after exactly two rising clock edges.
- R6: With polarity 1 the conditioned result is the inverse of the synchronized raw input.
- R7: Blanking code 1 gates with `blank_src[0]` and code 2 gates with `blank_src[1]`. While the selected input is 1, `cmp_out` is 0. Code 0 and codes 3 to 7 never gate.
- R8: With enable 0, `cmp_out` and bit 30 are 0.
- R9: `ana_minus_sel` equals the programmed minus select, except in one case. When scaler enable is 1, bridge enable is 0 and the code is 0, 1 or 2, it reads 3 (full reference).
- R10: `ana_plus_oh` is one-hot: plus select 00 gives 3'b001, 01 gives 3'b010, and 10 or 11 gives 3'b100.
- R11: Reads at any other address return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| comp_raw | input | 1 | Asynchronous raw comparator decision |
| blank_src | input | NUM_BLANK | Timer blanking inputs, active high |
| ana_en | output | 1 | Comparator enable |
| ana_pwr | output | 2 | Power mode: 00 fast, 01/10 medium, 11 ultra-low power |
| ana_minus_sel | output | 3 | Effective minus-input select after remap |
| ana_plus_oh | output | 3 | One-hot plus-input select |
| ana_hyst | output | 2 | Hysteresis: none, low, medium, high |
| ana_scaler_en | output | 1 | Reference scaler enable |
| ana_bridge_en | output | 1 | Scaler divider bridge enable |
| cmp_out | output | 1 | Synchronized, polarity-corrected, blanked result |

## Verification
The conditioning path is driven with the raw input held at each level under both polarities. This separates a missing or doubled inversion from a wrong synchronizer depth, which shows up as a one-cycle early or late edge. Blanking is tried with each timer input high while the other is low, and with a reserved code while both are high. This exposes swapped sources and reserved codes that gate. The remap is tried with the scaler alone, with scaler and bridge together, and with neither. Fractional and pin codes are both used, so a remap that is too wide or too narrow is caught. A lock is followed by clearing and setting writes, then by reset, to separate a lock that is sticky from one that is merely slow.

// File: rtl/cmp_csr_pkg.sv
package cmp_csr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned EN_B    = 0;
  localparam int unsigned PWR_LO  = 2;
  localparam int unsigned INM_LO  = 4;
  localparam int unsigned INP_LO  = 7;
  localparam int unsigned POL_B   = 15;
  localparam int unsigned HYST_LO = 16;
  localparam int unsigned BLK_LO  = 18;
  localparam int unsigned BRG_B   = 22;
  localparam int unsigned SCL_B   = 23;
  localparam int unsigned STAT_B  = 30;
  localparam int unsigned LOCK_B  = 31;
  localparam logic [2:0]  FULL_REF_CODE = 3'd3;
  localparam logic [2:0]  LAST_FRAC_CODE = 3'd2;

  typedef struct packed {
    logic       en;
    logic [1:0] pwr;
    logic [2:0] inm;
    logic [1:0] inp;
    logic       pol;
    logic [1:0] hyst;
    logic [2:0] blk;
    logic       brg;
    logic       scl;
  } csr_fields_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_csr_regs.sv
module cmp_csr_regs
  import cmp_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output csr_fields_t       fld,
  output logic              locked
);
  // One gate freezes the fields and the lock bit itself.
  logic upd;
  assign upd = wr_en && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld    <= '0;
      locked <= 1'b0;
    end else if (upd) begin
      fld.en   <= wdata[EN_B];
      fld.pwr  <= wdata[PWR_LO +: 2];
      fld.inm  <= wdata[INM_LO +: 3];
      fld.inp  <= wdata[INP_LO +: 2];
      fld.pol  <= wdata[POL_B];
      fld.hyst <= wdata[HYST_LO +: 2];
      fld.blk  <= wdata[BLK_LO +: 3];
      fld.brg  <= wdata[BRG_B];
      fld.scl  <= wdata[SCL_B];
      locked   <= wdata[LOCK_B];
    end
  end
endmodule

// File: rtl/cmp_route_map.sv
module cmp_route_map
  import cmp_csr_pkg::*;
(
  input  logic [2:0] inm,
  input  logic [1:0] inp,
  input  logic       scl,
  input  logic       brg,
  output logic [2:0] minus_eff,
  output logic [2:0] plus_oh
);
  // Without the bridge only the full reference exists, so fractions collapse onto it.
  always_comb begin
    minus_eff = inm;
    if (scl && !brg && (inm <= LAST_FRAC_CODE)) minus_eff = FULL_REF_CODE;
  end

  always_comb begin
    unique case (inp)
      2'b00:   plus_oh = 3'b001;
      2'b01:   plus_oh = 3'b010;
      default: plus_oh = 3'b100;
    endcase
  end
endmodule

// File: rtl/cmp_condition.sv
module cmp_condition #(
  parameter int unsigned NUM_BLANK = 2
) (
  input  logic                 sync_q,
  input  logic                 en,
  input  logic                 pol,
  input  logic [2:0]           blk,
  input  logic [NUM_BLANK-1:0] blank_src,
  output logic                 status,
  output logic                 out
);
  logic [NUM_BLANK-1:0] gate_v;
  logic                 blank_active;

  // Code i+1 selects source i; everything else is treated as no blanking.
  for (genvar i = 0; i < NUM_BLANK; i++) begin : g_blank
    assign gate_v[i] = (blk == 3'(i + 1)) && blank_src[i];
  end

  assign blank_active = |gate_v;
  assign status       = en & (sync_q ^ pol);
  assign out          = status & ~blank_active;
endmodule

// File: rtl/cmp_ctl_csr.sv
module cmp_ctl_csr
  import cmp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CSR_ADDR  = 0,
  parameter int unsigned NUM_BLANK = 2,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 comp_raw,
  input  logic [NUM_BLANK-1:0] blank_src,
  output logic                 ana_en,
  output logic [1:0]           ana_pwr,
  output logic [2:0]           ana_minus_sel,
  output logic [2:0]           ana_plus_oh,
  output logic [1:0]           ana_hyst,
  output logic                 ana_scaler_en,
  output logic                 ana_bridge_en,
  output logic                 cmp_out
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_ADDR);

  csr_fields_t fld;
  logic        locked;
  logic        hit;
  logic        sync_q;
  logic        stat_bit;

  assign hit = (bus_addr == HIT_ADDR);

  cmp_csr_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (hit && bus_we),
    .wdata  (bus_wdata),
    .fld    (fld),
    .locked (locked)
  );

  cmp_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comp_raw),
    .q     (sync_q)
  );

  cmp_condition #(.NUM_BLANK(NUM_BLANK)) u_cond (
    .sync_q    (sync_q),
    .en        (fld.en),
    .pol       (fld.pol),
    .blk       (fld.blk),
    .blank_src (blank_src),
    .status    (stat_bit),
    .out       (cmp_out)
  );

  cmp_route_map u_route (
    .inm       (fld.inm),
    .inp       (fld.inp),
    .scl       (fld.scl),
    .brg       (fld.brg),
    .minus_eff (ana_minus_sel),
    .plus_oh   (ana_plus_oh)
  );

  assign ana_en        = fld.en;
  assign ana_pwr       = fld.pwr;
  assign ana_hyst      = fld.hyst;
  assign ana_scaler_en = fld.scl;
  assign ana_bridge_en = fld.brg;

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[EN_B]          = fld.en;
      bus_rdata[PWR_LO +: 2]   = fld.pwr;
      bus_rdata[INM_LO +: 3]   = fld.inm;
      bus_rdata[INP_LO +: 2]   = fld.inp;
      bus_rdata[POL_B]         = fld.pol;
      bus_rdata[HYST_LO +: 2]  = fld.hyst;
      bus_rdata[BLK_LO +: 3]   = fld.blk;
      bus_rdata[BRG_B]         = fld.brg;
      bus_rdata[SCL_B]         = fld.scl;
      bus_rdata[STAT_B]        = stat_bit;
      bus_rdata[LOCK_B]        = locked;
    end
  end
endmodule

// File: rtl/cmp_csr_chk.sv
module cmp_csr_chk #(
  parameter int unsigned NUM_BLANK = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 locked,
  input logic [15:0]          fld_bits,
  input logic                 en,
  input logic                 pol,
  input logic                 scl,
  input logic                 brg,
  input logic [2:0]           inm,
  input logic [2:0]           blk,
  input logic [NUM_BLANK-1:0] blank_src,
  input logic                 comp_raw,
  input logic                 stat_bit,
  input logic                 cmp_out,
  input logic [2:0]           ana_minus_sel,
  input logic [2:0]           ana_plus_oh
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(fld_bits));
  a_r5_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (stat_bit == (en & ($past(comp_raw, 2) ^ pol))));
  a_r7_blank0: assert property (@(posedge clk) disable iff (!rst_n)
    (blk == 3'd1 && blank_src[0]) |-> !cmp_out);
  a_r7_blank1: assert property (@(posedge clk) disable iff (!rst_n)
    (blk == 3'd2 && blank_src[NUM_BLANK-1]) |-> !cmp_out);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!cmp_out && !stat_bit));
  a_r9_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && !brg && inm <= 3'd2) |-> (ana_minus_sel == 3'd3));
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (brg || !scl || inm > 3'd2) |-> (ana_minus_sel == inm));
  a_r10_plus_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ana_plus_oh) == 1);
endmodule

bind cmp_ctl_csr cmp_csr_chk #(.NUM_BLANK(NUM_BLANK)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .locked        (locked),
  .fld_bits      (fld),
  .en            (fld.en),
  .pol           (fld.pol),
  .scl           (fld.scl),
  .brg           (fld.brg),
  .inm           (fld.inm),
  .blk           (fld.blk),
  .blank_src     (blank_src),
  .comp_raw      (comp_raw),
  .stat_bit      (stat_bit),
  .cmp_out       (cmp_out),
  .ana_minus_sel (ana_minus_sel),
  .ana_plus_oh   (ana_plus_oh)
);

// File: tb/tb_cmp_ctl_csr.sv
`timescale 1ns/1ps
module tb_cmp_ctl_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        comp_raw = 1'b0;
  logic [1:0]  blank_src = '0;
  logic        ana_en, ana_scaler_en, ana_bridge_en, cmp_out;
  logic [1:0]  ana_pwr, ana_hyst;
  logic [2:0]  ana_minus_sel, ana_plus_oh;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmp_ctl_csr dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .comp_raw(comp_raw),
    .blank_src(blank_src), .ana_en(ana_en), .ana_pwr(ana_pwr),
    .ana_minus_sel(ana_minus_sel), .ana_plus_oh(ana_plus_oh),
    .ana_hyst(ana_hyst), .ana_scaler_en(ana_scaler_en),
    .ana_bridge_en(ana_bridge_en), .cmp_out(cmp_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v);
    chk("R1 readback", v, 32'h0);
    chk("R1 cmp_out", {31'b0, cmp_out}, 32'h0);
    chk("R1 plus_oh", {29'b0, ana_plus_oh}, 32'h1);
  endtask

  task automatic t_rw();
    logic [31:0] v;
    comp_raw = 1'b0;
    wr(4'd0, 32'h7FFF_7FFF);
    rd(4'd0, v);
    chk("R2/R4 readback mask", v, 32'h00DF_01FD);
    chk("R2 pwr/hyst/en", {27'b0, ana_pwr, ana_hyst, ana_en}, {27'b0, 2'b11, 2'b11, 1'b1});
    chk("R9 minus pin code", {29'b0, ana_minus_sel}, 32'd7);
  endtask

  task automatic t_other_addr();
    logic [31:0] v;
    wr(4'd0, 32'h0000_0005);
    wr(4'd1, 32'h0000_0000);
    rd(4'd0, v);
    chk("R11 write elsewhere ignored", v, 32'h0000_0005);
    rd(4'd1, v);
    chk("R11 read elsewhere", v, 32'h0);
  endtask

  task automatic t_sync_pol();
    logic [31:0] v;
    comp_raw = 1'b0;
    wr(4'd0, 32'h0000_0001);
    repeat (2) @(negedge clk);
    comp_raw = 1'b1;
    @(negedge clk);
    chk("R5 one edge not yet", {31'b0, cmp_out}, 32'h0);
    @(negedge clk);
    chk("R5 two edges", {31'b0, cmp_out}, 32'h1);
    rd(4'd0, v);
    chk("R4 status follows", {31'b0, v[30]}, 32'h1);
    wr(4'd0, 32'h0000_8001);
    chk("R6 inverted high", {31'b0, cmp_out}, 32'h0);
    comp_raw = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 inverted low", {31'b0, cmp_out}, 32'h1);
    rd(4'd0, v);
    chk("R4 status inverted", {31'b0, v[30]}, 32'h1);
  endtask

  task automatic t_blank();
    comp_raw = 1'b1;
    wr(4'd0, 32'h0004_0001);
    repeat (2) @(negedge clk);
    blank_src = 2'b01; #1;
    chk("R7 code1 src0 gates", {31'b0, cmp_out}, 32'h0);
    blank_src = 2'b10; #1;
    chk("R7 code1 ignores src1", {31'b0, cmp_out}, 32'h1);
    wr(4'd0, 32'h0008_0001);
    chk("R7 code2 src1 gates", {31'b0, cmp_out}, 32'h0);
    blank_src = 2'b01; #1;
    chk("R7 code2 ignores src0", {31'b0, cmp_out}, 32'h1);
    wr(4'd0, 32'h0014_0001);
    blank_src = 2'b11; #1;
    chk("R7 reserved code no gate", {31'b0, cmp_out}, 32'h1);
    blank_src = 2'b00;
  endtask

  task automatic t_enable();
    logic [31:0] v;
    comp_raw = 1'b1;
    wr(4'd0, 32'h0000_0000);
    repeat (2) @(negedge clk);
    chk("R8 out off", {31'b0, cmp_out}, 32'h0);
    rd(4'd0, v);
    chk("R8 status off", {31'b0, v[30]}, 32'h0);
  endtask

  task automatic t_remap();
    wr(4'd0, 32'h0080_0010);
    chk("R9 scaler only frac->full", {29'b0, ana_minus_sel}, 32'd3);
    wr(4'd0, 32'h0080_0050);
    chk("R9 scaler only pin code", {29'b0, ana_minus_sel}, 32'd5);
    wr(4'd0, 32'h00C0_0010);
    chk("R9 bridge keeps frac", {29'b0, ana_minus_sel}, 32'd1);
    wr(4'd0, 32'h0000_0020);
    chk("R9 scaler off keeps frac", {29'b0, ana_minus_sel}, 32'd2);
  endtask

  task automatic t_plus();
    wr(4'd0, 32'h0000_0000);
    chk("R10 plus 00", {29'b0, ana_plus_oh}, 32'h1);
    wr(4'd0, 32'h0000_0080);
    chk("R10 plus 01", {29'b0, ana_plus_oh}, 32'h2);
    wr(4'd0, 32'h0000_0100);
    chk("R10 plus 10", {29'b0, ana_plus_oh}, 32'h4);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    comp_raw = 1'b0;
    wr(4'd0, 32'h8000_0005);
    repeat (2) @(negedge clk);
    rd(4'd0, v);
    chk("R3 lock set", v, 32'h8000_0005);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, v);
    chk("R3 clear ignored", v, 32'h8000_0005);
    wr(4'd0, 32'h7FFF_FFFF);
    rd(4'd0, v);
    chk("R3 set ignored", v, 32'h8000_0005);
    do_reset();
    rd(4'd0, v);
    chk("R3 reset clears lock", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_rw();
    t_other_addr();
    t_sync_pol();
    t_blank();
    t_enable();
    t_remap();
    t_plus();
    t_lock();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule